// File: doc/BRIEF.md
# Inverse-Transform Discrete Gaussian Sampler

This block draws small signed integers that follow a narrow discrete Gaussian, as needed for the noise and secret polynomials of ring lattice encryption. It takes 128-bit words of uniform random bits from a pseudo-random generator. It cuts each word into five 25-bit groups and turns every group into one sample. In each group the top bit picks the sign and the lower 24 bits are a uniform value. That value is compared at the same time against a table of cumulative thresholds that covers only the non-negative half of the distribution. The lowest threshold index that the value does not exceed is the magnitude.

Samples go into a small FIFO as a sign and a magnitude. As each sample leaves the FIFO it is mapped into the coefficient range 0 to q-1: a negative value becomes q minus its magnitude. The threshold table, q, the tail bound and the FIFO depth are all parameters fixed at elaboration. One group is turned into a sample in every cycle in which the FIFO has room, whatever random value is drawn. When the FIFO is full the random word is held and the generator is stalled. No random bits are dropped.

Top module: `gauss_itm_sampler`

## Requirements
- R1: Group k (k = 0..4) of an accepted word is bits [25k+24 : 25k]. Bit 25k+24 is the sign (1 = negative) and bits [25k+23 : 25k] are the uniform value. Bits 127:125 have no effect on any sample.
- R2: The magnitude is the smallest index i, from 0 to 23, for which the uniform value is less than or equal to threshold v_i. The top threshold v_23 is 2^24-1, so every value gets a magnitude.
- R3: A uniform value equal to v_i gives magnitude i. A value equal to v_i + 1 gives magnitude i + 1.
- R4: A positive sample of magnitude l is output as l. A negative sample of magnitude l > 0 is output as q - l (q = 7681). Every output coefficient is below q.
- R5: A sample of magnitude 0 is output as 0 whatever its sign bit.
- R6: The timing does not depend on the data. When the FIFO has room, an accepted word gives its five samples in five consecutive cycles. The first sample is visible on the output one clock after the accepting clock edge. The next word is accepted on the edge that produces the fifth sample.
- R7: When the FIFO is full, the slicer holds its place in the current word and prng_ready stays low. Once the output drains, every held sample is delivered and none is lost or repeated.
- R8: After reset, smp_valid is 0 and prng_ready is 1.
- R9: Samples leave in acceptance order: group 0 to group 4 of a word, and word by word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prng_valid | input | 1 | A random word is offered |
| prng_ready | output | 1 | The block takes the offered word on this edge |
| prng_word | input | 128 | Uniform random bits |
| smp_valid | output | 1 | A sample is available |
| smp_ready | input | 1 | The consumer takes the sample on this edge |
| smp_coef | output | 13 | Sample lifted into 0..q-1 |

## Verification
Uniform values are chosen exactly on a threshold and one above it, at the low end (0, v_0), in the middle (v_5) and at the top (v_22, all ones). These separate a less-or-equal compare from a less-than compare and an off-by-one priority select. Each value is tried with both signs, which separates the q - l lift from a plain pass-through and shows that zero ignores the sign. The same groups are sent with different values in the three unused top bits, and with the output stalled and then released. Checking the arrival cycle of every sample separates a constant-rate slicer from one whose pace follows the data, the full FIFO or the consumer.

// File: rtl/gsamp_pkg.sv
package gsamp_pkg;

   localparam int DEF_WORD_W  = 128;
   localparam int DEF_UNI_W   = 24;
   localparam int DEF_MAX_MAG = 23;
   localparam int DEF_Q       = 7681;
   localparam int DEF_DEPTH   = 8;

   // Cumulative thresholds over the non-negative half, entry i at bits [24i +: 24].
   // Scaled so that the last entry reaches the top of the 24-bit uniform range.
   localparam logic [(DEF_MAX_MAG+1)*DEF_UNI_W-1:0] DEF_THRESH = {
      24'd16777215, 24'd16777205, 24'd16777190, 24'd16777160,
      24'd16777100, 24'd16777000, 24'd16775966, 24'd16773476,
      24'd16767904, 24'd16755986, 24'd16731712, 24'd16684638,
      24'd16597788, 24'd16445132, 24'd16189900, 24'd15782924,
      24'd15165464, 24'd14273844, 24'd13047542, 24'd11441562,
      24'd9439246,  24'd7061978,  24'd4374606,  24'd1482114
   };

endpackage

// File: rtl/gsamp_slicer.sv
module gsamp_slicer #(
   parameter int WORD_W = 128,
   parameter int GRP_W  = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prng_valid,
   output logic              prng_ready,
   input  logic [WORD_W-1:0] prng_word,
   input  logic              fifo_full,
   output logic              push,
   output logic [GRP_W-1:0]  grp
);

   localparam int GROUPS = WORD_W / GRP_W;
   localparam int USED_W = GROUPS * GRP_W;
   localparam int CNT_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUPS - 1);

   logic [USED_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt;
   logic              loaded;
   logic              last;
   logic              accept;

   generate
      if (USED_W < WORD_W) begin : g_spare
         logic unused_spare_bits;
         assign unused_spare_bits = ^prng_word[WORD_W-1:USED_W];
      end
   endgenerate

   assign last       = (cnt == LAST_IDX);
   assign push       = loaded && !fifo_full;
   assign prng_ready = !loaded || (push && last);
   assign accept     = prng_valid && prng_ready;
   assign grp        = word_q[int'(cnt)*GRP_W +: GRP_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         cnt    <= '0;
         loaded <= 1'b0;
      end else if (accept) begin
         word_q <= prng_word[USED_W-1:0];
         cnt    <= '0;
         loaded <= 1'b1;
      end else if (push) begin
         if (last) begin
            loaded <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && fifo_full && !prng_ready) |=> (loaded && $stable(cnt))) else $error("hold"); // R7

   AST_WORD_START: assert property (@(posedge clk) disable iff (!rst_n)
      (prng_valid && prng_ready) |=> (loaded && cnt == '0)) else $error("start"); // R6

endmodule

// File: rtl/gsamp_cdf_select.sv
module gsamp_cdf_select #(
   parameter int UNI_W   = 24,
   parameter int MAX_MAG = 23,
   parameter logic [(MAX_MAG+1)*UNI_W-1:0] THRESH = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         check_en,
   input  logic [UNI_W-1:0]             uni,
   output logic [$clog2(MAX_MAG+1)-1:0] mag
);

   localparam int NCMP  = MAX_MAG + 1;
   localparam int MAG_W = $clog2(NCMP);

   logic [NCMP-1:0] hit;

   generate
      for (genvar i = 0; i < NCMP; i++) begin : g_cmp
         assign hit[i] = (uni <= THRESH[i*UNI_W +: UNI_W]);
      end
   endgenerate

   always_comb begin
      mag = MAG_W'(MAX_MAG);
      for (int i = MAX_MAG; i >= 0; i--) begin
         if (hit[i]) mag = MAG_W'(i);
      end
   end

   logic [UNI_W-1:0] sel_thr;
   logic [UNI_W-1:0] below_thr;
   always_comb begin
      sel_thr   = THRESH[int'(mag)*UNI_W +: UNI_W];
      below_thr = '0;
      if (mag != '0) below_thr = THRESH[(int'(mag)-1)*UNI_W +: UNI_W];
   end

   AST_MAG_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      check_en |-> (uni <= sel_thr)) else $error("covers"); // R2

   AST_MAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (check_en && mag != '0) |-> (uni > below_thr)) else $error("first"); // R3

endmodule

// File: rtl/gsamp_fifo.sv
module gsamp_fifo #(
   parameter int DATA_W = 6,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   output logic              full,
   input  logic              pop,
   output logic              not_empty,
   output logic [DATA_W-1:0] rdata
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  rd_ptr;
   logic [PTR_W:0]    count;

   assign full      = (count == FULL_CNT);
   assign not_empty = (count != '0);
   assign rdata     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full)) else $error("overflow"); // R7

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && !not_empty)) else $error("underflow"); // R9

endmodule

// File: rtl/gsamp_lift.sv
module gsamp_lift #(
   parameter int MAG_W  = 5,
   parameter int Q      = 7681,
   parameter int COEF_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              neg,
   input  logic [MAG_W-1:0]  mag,
   output logic [COEF_W-1:0] coef
);

   localparam logic [COEF_W-1:0] QV = COEF_W'(Q);

   always_comb begin
      if (neg && mag != '0) coef = QV - COEF_W'(mag);
      else                  coef = COEF_W'(mag);
   end

   AST_LIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (coef < QV)) else $error("range"); // R4

   AST_ZERO_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mag == '0) |-> (coef == '0)) else $error("zero"); // R5

endmodule

// File: rtl/gauss_itm_sampler.sv
module gauss_itm_sampler
   import gsamp_pkg::*;
#(
   parameter int WORD_W  = DEF_WORD_W,
   parameter int UNI_W   = DEF_UNI_W,
   parameter int MAX_MAG = DEF_MAX_MAG,
   parameter int Q       = DEF_Q,
   parameter int DEPTH   = DEF_DEPTH,
   parameter logic [(MAX_MAG+1)*UNI_W-1:0] THRESH = DEF_THRESH,
   localparam int COEF_W = $clog2(Q)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prng_valid,
   output logic              prng_ready,
   input  logic [WORD_W-1:0] prng_word,
   output logic              smp_valid,
   input  logic              smp_ready,
   output logic [COEF_W-1:0] smp_coef
);

   localparam int GRP_W  = UNI_W + 1;
   localparam int MAG_W  = $clog2(MAX_MAG + 1);
   localparam int ENT_W  = MAG_W + 1;

   initial begin
      assert (WORD_W >= GRP_W) else $error("word narrower than one group");
      assert (MAX_MAG >= 1 && MAX_MAG < Q) else $error("tail bound out of range");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("depth must be a power of two");
      assert (THRESH[MAX_MAG*UNI_W +: UNI_W] == {UNI_W{1'b1}}) else $error("top threshold must be all ones");
      for (int i = 1; i <= MAX_MAG; i++) begin
         assert (THRESH[i*UNI_W +: UNI_W] >= THRESH[(i-1)*UNI_W +: UNI_W])
            else $error("thresholds must not decrease");
      end
   end

   logic             fifo_full;
   logic             push;
   logic [GRP_W-1:0] grp;
   logic [MAG_W-1:0] grp_mag;
   logic [ENT_W-1:0] head;
   logic             pop;

   gsamp_slicer #(.WORD_W(WORD_W), .GRP_W(GRP_W)) u_slicer (
      .clk        (clk),
      .rst_n      (rst_n),
      .prng_valid (prng_valid),
      .prng_ready (prng_ready),
      .prng_word  (prng_word),
      .fifo_full  (fifo_full),
      .push       (push),
      .grp        (grp)
   );

   gsamp_cdf_select #(.UNI_W(UNI_W), .MAX_MAG(MAX_MAG), .THRESH(THRESH)) u_cdf (
      .clk      (clk),
      .rst_n    (rst_n),
      .check_en (push),
      .uni      (grp[UNI_W-1:0]),
      .mag      (grp_mag)
   );

   assign pop = smp_valid && smp_ready;

   gsamp_fifo #(.DATA_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .wdata     ({grp[GRP_W-1], grp_mag}),
      .full      (fifo_full),
      .pop       (pop),
      .not_empty (smp_valid),
      .rdata     (head)
   );

   gsamp_lift #(.MAG_W(MAG_W), .Q(Q), .COEF_W(COEF_W)) u_lift (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (smp_valid),
      .neg   (head[ENT_W-1]),
      .mag   (head[MAG_W-1:0]),
      .coef  (smp_coef)
   );

   AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !smp_ready) |-> !push) else $error("stall"); // R7

endmodule

// File: tb/gauss_itm_sampler_bench.sv
`timescale 1ns/1ps
module gauss_itm_sampler_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         prng_valid = 1'b0;
   logic         prng_ready;
   logic [127:0] prng_word = '0;
   logic         smp_valid;
   logic         smp_ready = 1'b0;
   logic [12:0]  smp_coef;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ng = 0;
   int got [64];
   int gcyc [64];
   bit done = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   gauss_itm_sampler u_gauss_itm_sampler (
      .clk(clk), .rst_n(rst_n),
      .prng_valid(prng_valid), .prng_ready(prng_ready), .prng_word(prng_word),
      .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_coef(smp_coef)
   );

   always @(negedge clk) begin
      if (rst_n && smp_valid && smp_ready) begin
         got[ng]  = int'(smp_coef);
         gcyc[ng] = cyc;
         ng = ng + 1;
      end
   end

   // {sign, uniform[23:0], expected coefficient[12:0]}
   localparam logic [37:0] VEC [10] = '{
      {1'b0, 24'd0,        13'd0},    // R2 lowest value
      {1'b1, 24'd0,        13'd0},    // R5 negative zero
      {1'b0, 24'd1482114,  13'd0},    // R3 equal to v0
      {1'b0, 24'd1482115,  13'd1},    // R3 just above v0
      {1'b1, 24'd13047542, 13'd7676}, // R4 equal to v5, negative
      {1'b1, 24'd13047543, 13'd7675}, // R3 above v5, negative
      {1'b0, 24'd16777215, 13'd23},   // R2 top of range
      {1'b1, 24'd16777215, 13'd7658}, // R4 top, negative
      {1'b1, 24'd16777205, 13'd7659}, // R3 equal to v22
      {1'b0, 24'd16777206, 13'd23}    // R3 just above v22
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [127:0] mkword(input int first, input logic [2:0] junk);
      logic [127:0] w = '0;
      for (int k = 0; k < 5; k++) w[k*25 +: 25] = VEC[first+k][37:13];
      w[127:125] = junk;
      return w;
   endfunction

   task automatic send(input logic [127:0] w, output int acc);
      @(negedge clk);
      prng_valid = 1'b1;
      prng_word  = w;
      while (!prng_ready) @(negedge clk);
      acc = cyc;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      prng_valid = 1'b0;
   endtask

   task automatic wait_n(input int n);
      while (ng < n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", ng, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int acc0, acc1, base;
      repeat (3) @(negedge clk);
      chk(smp_valid == 1'b0, "R8 smp_valid after reset", int'(smp_valid), 0);
      chk(prng_ready == 1'b1, "R8 prng_ready after reset", int'(prng_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: two words back to back, output always ready.
      smp_ready = 1'b1;
      base = ng;
      send(mkword(0, 3'b111), acc0);
      send(mkword(5, 3'b010), acc1);
      idle();
      wait_n(base + 10);
      for (int i = 0; i < 10; i++)
         chk(got[base+i] == int'(VEC[i][12:0]), "R1/R2/R3/R4/R5/R9 table sample",
             got[base+i], int'(VEC[i][12:0]));
      chk(gcyc[base] - acc0 == 2, "R6 first sample latency word0", gcyc[base] - acc0, 2);
      chk(gcyc[base+5] - acc1 == 2, "R6 first sample latency word1", gcyc[base+5] - acc1, 2);
      chk(acc1 - acc0 == 5, "R6 next word acceptance", acc1 - acc0, 5);
      for (int i = 1; i < 10; i++)
         chk(gcyc[base+i] - gcyc[base+i-1] == 1, "R6 consecutive samples",
             gcyc[base+i] - gcyc[base+i-1], 1);

      // Spare top bits must not matter.
      repeat (3) @(negedge clk);
      base = ng;
      send(mkword(0, 3'b000), acc0);
      idle();
      wait_n(base + 5);
      for (int i = 0; i < 5; i++)
         chk(got[base+i] == int'(VEC[i][12:0]), "R1 spare bits ignored",
             got[base+i], int'(VEC[i][12:0]));

      // Back-pressure: output stalled, two words offered, eight fit.
      repeat (3) @(negedge clk);
      smp_ready = 1'b0;
      base = ng;
      send(mkword(5, 3'b101), acc0);
      send(mkword(0, 3'b011), acc1);
      @(negedge clk);
      prng_word = mkword(5, 3'b000);
      repeat (10) @(negedge clk);
      chk(prng_ready == 1'b0, "R7 ready low while full", int'(prng_ready), 0);
      chk(smp_valid == 1'b1, "R7 samples held while stalled", int'(smp_valid), 1);
      chk(ng == base, "R7 nothing taken while stalled", ng - base, 0);
      prng_valid = 1'b0;
      smp_ready = 1'b1;
      wait_n(base + 10);
      repeat (8) @(negedge clk);
      chk(ng == base + 10, "R7 no extra samples", ng - base, 10);
      for (int i = 0; i < 10; i++)
         chk(got[base+i] == int'(VEC[(i+5)%10][12:0]), "R7/R9 order after stall",
             got[base+i], int'(VEC[(i+5)%10][12:0]));

      // Reset again while idle.
      rst_n = 1'b0;
      @(negedge clk);
      chk(smp_valid == 1'b0, "R8 smp_valid after second reset", int'(smp_valid), 0);
      chk(prng_ready == 1'b1, "R8 prng_ready after second reset", int'(prng_ready), 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule